// File: doc/BRIEF.md
# Dual-Converter Simultaneous Sequence Controller

This block drives two converters, a master and a slave, that sample in lock-step through a programmed list of channels. A trigger in the idle state starts both converters together on the current list entry. The block waits until both have reported end of conversion. It then packs the two results into one paired word and either moves on to the next entry or stops. The list may be split into sub-groups, and each sub-group then needs its own trigger.

An optional read-gated mode holds the controller after every completed pair until software or a transfer engine has read the paired word. The next pair starts only after that read. At the end of a sub-group or of the whole list, the read gate also decides when a new trigger is accepted. Triggers that arrive while the controller is busy or held are dropped. A one-cycle transfer request accompanies each stored pair when the transfer mode allows it. A length mismatch between the master and slave lists is flagged, and starting is then refused.

Top module: `dual_seq_ctrl`

## Requirements
- R1: While idle and enabled with a valid configuration, a trigger makes `m_start` and `s_start` pulse high together for one cycle, in the cycle after the trigger. `m_chan`/`s_chan` then show the list entries at the current position. Entry k of a list occupies bits [k*CH_W +: CH_W].
- R2: A pair completes only once both `m_eoc` and `s_eoc` have been seen, in either order. One cycle after the later of the two, `pair_word` holds {slave data, master data}, with the slave in the upper half and the master in the lower half. Each half takes the data present in the cycle of that converter's own `m_eoc` or `s_eoc`. Until the pair completes, `pair_word` keeps its old value.
- R3: Entries are converted in list order from 0 to `m_len_m1`. `eos` pulses for one cycle after the last pair, together with the updated `pair_word`. The position then returns to entry 0.
- R4: With splitting and read gating both off, each pair after the first starts automatically in the cycle after the previous pair completes.
- R5: With `split_en`=1, each trigger runs `split_m1`+1 pairs, or fewer if the list ends first. The controller then stays idle until the next trigger, which resumes at the following entry.
- R6: With `rd_gate_en`=1, after a pair that is not the end of a sub-group or of the list, no start is issued until `pw_rd` or `m_rd` pulses. The start pulse follows one cycle after the read.
- R7: With `rd_gate_en`=1, after the end of a sub-group or of the list, triggers are ignored until `pw_rd` pulses. `m_rd` does not release this hold.
- R8: Triggers that arrive while a pair is converting, or while the controller is held, are discarded and never queued.
- R9: When `m_len_m1` differs from `s_len_m1`, `cfg_err` is high and triggers start nothing.
- R10: `xfer_req` pulses together with each new `pair_word` when `xfer_mode`≠2'b00, and either read gating is off or `xfer_mode` is 2'b10 or 2'b11. Otherwise it stays low.
- R11: Driving `en` low returns the controller to idle within one cycle. It drops any pending read hold and resets the position to entry 0.
- R12: After reset, `m_start`, `s_start`, `eos` and `xfer_req` are low, `pair_word` is zero and the position is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable |
| trig | input | 1 | Start trigger |
| m_len_m1 | input | LEN_W | Master list length minus one |
| s_len_m1 | input | LEN_W | Slave list length minus one |
| m_list | input | MAX_LEN*CH_W | Master channel list, packed |
| s_list | input | MAX_LEN*CH_W | Slave channel list, packed |
| split_en | input | 1 | Sub-group mode enable |
| split_m1 | input | SPLIT_W | Sub-group size minus one |
| rd_gate_en | input | 1 | Read-gated hold mode enable |
| xfer_mode | input | 2 | Transfer mode: 00 off, 01 single, 1x multi |
| m_eoc | input | 1 | Master end of conversion |
| s_eoc | input | 1 | Slave end of conversion |
| m_data | input | DW | Master result |
| s_data | input | DW | Slave result |
| pw_rd | input | 1 | Read strobe of the paired word |
| m_rd | input | 1 | Read strobe of the master result |
| m_start | output | 1 | Master start pulse |
| s_start | output | 1 | Slave start pulse |
| m_chan | output | CH_W | Master channel index |
| s_chan | output | CH_W | Slave channel index |
| pair_word | output | 2*DW | Paired result {slave, master} |
| eos | output | 1 | End-of-list pulse |
| xfer_req | output | 1 | Transfer request pulse |
| cfg_err | output | 1 | List length mismatch |

## Verification
A wrong sequence position shows on `m_chan` in the same cycle as the start pulse that follows. It also shows on the entry-0 index after `eos`, one cycle after the last pair. A controller stuck in a hold state shows as a missing start pulse one cycle after the releasing read. A hold that releases too early shows as a start pulse with no read at all. A pair-tracking fault, such as an early completion or a half captured at the wrong time, shows in `pair_word` one cycle after the later end-of-conversion. To catch this, the bench drives junk data outside each end-of-conversion cycle.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONV    = 2'd1,
    ST_HOLD    = 2'd2,
    ST_HOLDEND = 2'd3
  } st_t;

  // transfer request permitted for this mode / gating combination
  function automatic logic xfer_permit(input logic [1:0] mode, input logic gate);
    return (mode != 2'b00) && (!gate || mode[1]);
  endfunction

  // a run of pairs stops at the end of a sub-group or of the list
  function automatic logic run_stops(input logic seq_last, input logic sub_last);
    return seq_last || sub_last;
  endfunction

endpackage

// File: rtl/dsq_pair_track.sv
module dsq_pair_track #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            active,
  input  logic            m_eoc,
  input  logic            s_eoc,
  input  logic [DW-1:0]   m_data,
  input  logic [DW-1:0]   s_data,
  output logic            pair_done,
  output logic [2*DW-1:0] pair_word
);

  logic          m_done, s_done;
  logic [DW-1:0] m_res, s_res;
  logic          m_have, s_have;
  logic [DW-1:0] m_now, s_now;

  function automatic logic [2*DW-1:0] pack_pair(input logic [DW-1:0] sv,
                                                input logic [DW-1:0] mv);
    return {sv, mv};
  endfunction

  always_comb begin
    m_have    = m_done || m_eoc;
    s_have    = s_done || s_eoc;
    pair_done = active && m_have && s_have;
    m_now     = m_eoc ? m_data : m_res;
    s_now     = s_eoc ? s_data : s_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done    <= 1'b0;
      s_done    <= 1'b0;
      m_res     <= '0;
      s_res     <= '0;
      pair_word <= '0;
    end else if (clr) begin
      m_done <= 1'b0;
      s_done <= 1'b0;
    end else if (pair_done) begin
      m_done    <= 1'b0;
      s_done    <= 1'b0;
      pair_word <= pack_pair(s_now, m_now);
    end else if (active) begin
      if (m_eoc) begin
        m_done <= 1'b1;
        m_res  <= m_data;
      end
      if (s_eoc) begin
        s_done <= 1'b1;
        s_res  <= s_data;
      end
    end
  end

endmodule

// File: rtl/dsq_pos_ctr.sv
module dsq_pos_ctr #(
  parameter int LEN_W   = 4,
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [LEN_W-1:0]   len_m1,
  input  logic               split_en,
  input  logic [SPLIT_W-1:0] split_m1,
  output logic [LEN_W-1:0]   pos,
  output logic               seq_last,
  output logic               sub_last
);

  logic [SPLIT_W-1:0] sub_q;

  always_comb begin
    seq_last = (pos == len_m1);
    sub_last = split_en && (sub_q == split_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      sub_q <= '0;
    end else if (clr) begin
      pos   <= '0;
      sub_q <= '0;
    end else if (step) begin
      if (seq_last) begin
        pos   <= '0;
        sub_q <= '0;
      end else begin
        pos   <= pos + 1'b1;
        sub_q <= sub_last ? '0 : sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dsq_fsm.sv
module dsq_fsm
  import dsq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig,
  input  logic cfg_err,
  input  logic rd_gate_en,
  input  logic pair_done,
  input  logic seq_last,
  input  logic sub_last,
  input  logic pw_rd,
  input  logic m_rd,
  output st_t  st,
  output logic start_evt,
  output logic active
);

  st_t nxt;
  logic stop;

  always_comb begin
    nxt       = st;
    start_evt = 1'b0;
    stop      = run_stops(seq_last, sub_last);
    case (st)
      ST_IDLE: begin
        if (trig && !cfg_err) begin
          nxt       = ST_CONV;
          start_evt = 1'b1;
        end
      end
      ST_CONV: begin
        if (pair_done) begin
          if (rd_gate_en) begin
            nxt = stop ? ST_HOLDEND : ST_HOLD;
          end else if (stop) begin
            nxt = ST_IDLE;
          end else begin
            start_evt = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (pw_rd || m_rd) begin
          nxt       = ST_CONV;
          start_evt = 1'b1;
        end
      end
      ST_HOLDEND: begin
        if (pw_rd) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    if (!en) begin
      nxt       = ST_IDLE;
      start_evt = 1'b0;
    end
    active = (st == ST_CONV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

endmodule

// File: rtl/dual_seq_ctrl.sv
module dual_seq_ctrl
  import dsq_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CH_W    = 5,
  parameter int DW      = 16,
  parameter int SPLIT_W = 3,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    trig,
  input  logic [LEN_W-1:0]        m_len_m1,
  input  logic [LEN_W-1:0]        s_len_m1,
  input  logic [MAX_LEN*CH_W-1:0] m_list,
  input  logic [MAX_LEN*CH_W-1:0] s_list,
  input  logic                    split_en,
  input  logic [SPLIT_W-1:0]      split_m1,
  input  logic                    rd_gate_en,
  input  logic [1:0]              xfer_mode,
  input  logic                    m_eoc,
  input  logic                    s_eoc,
  input  logic [DW-1:0]           m_data,
  input  logic [DW-1:0]           s_data,
  input  logic                    pw_rd,
  input  logic                    m_rd,
  output logic                    m_start,
  output logic                    s_start,
  output logic [CH_W-1:0]         m_chan,
  output logic [CH_W-1:0]         s_chan,
  output logic [2*DW-1:0]         pair_word,
  output logic                    eos,
  output logic                    xfer_req,
  output logic                    cfg_err
);

  st_t             st_q;
  logic            start_evt;
  logic            active;
  logic            pair_done;
  logic            seq_last;
  logic            sub_last;
  logic [LEN_W-1:0] pos_q;
  logic            start_q, eos_q, xfer_q;
  logic [CH_W-1:0] m_tab [MAX_LEN];
  logic [CH_W-1:0] s_tab [MAX_LEN];

  for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_unpack
    assign m_tab[gi] = m_list[gi*CH_W +: CH_W];
    assign s_tab[gi] = s_list[gi*CH_W +: CH_W];
  end

  assign cfg_err = (m_len_m1 != s_len_m1);

  dsq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .trig       (trig),
    .cfg_err    (cfg_err),
    .rd_gate_en (rd_gate_en),
    .pair_done  (pair_done),
    .seq_last   (seq_last),
    .sub_last   (sub_last),
    .pw_rd      (pw_rd),
    .m_rd       (m_rd),
    .st         (st_q),
    .start_evt  (start_evt),
    .active     (active)
  );

  dsq_pos_ctr #(.LEN_W(LEN_W), .SPLIT_W(SPLIT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!en),
    .step     (pair_done),
    .len_m1   (m_len_m1),
    .split_en (split_en),
    .split_m1 (split_m1),
    .pos      (pos_q),
    .seq_last (seq_last),
    .sub_last (sub_last)
  );

  dsq_pair_track #(.DW(DW)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en),
    .active    (active),
    .m_eoc     (m_eoc),
    .s_eoc     (s_eoc),
    .m_data    (m_data),
    .s_data    (s_data),
    .pair_done (pair_done),
    .pair_word (pair_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      eos_q   <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      start_q <= start_evt;
      eos_q   <= pair_done && seq_last;
      xfer_q  <= pair_done && xfer_permit(xfer_mode, rd_gate_en);
    end
  end

  assign m_start  = start_q;
  assign s_start  = start_q;
  assign eos      = eos_q;
  assign xfer_req = xfer_q;
  assign m_chan   = m_tab[pos_q];
  assign s_chan   = s_tab[pos_q];

endmodule

// File: rtl/dsq_chk.sv
module dsq_chk
  import dsq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pw_rd,
  input logic             m_rd,
  input logic             cfg_err,
  input logic             m_start,
  input logic             eos,
  input st_t              st,
  input logic [LEN_W-1:0] pos
);

  a_r3_wrap_on_eos: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> (pos == '0));

  a_r6_hold_waits_read: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_HOLD && !pw_rd && !m_rd) |=> (st == ST_HOLD));

  a_r7_end_hold_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLDEND) |=> !m_start);

  a_r9_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cfg_err) |=> (st == ST_IDLE));

  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == ST_IDLE && pos == '0));

endmodule

bind dual_seq_ctrl dsq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .pw_rd   (pw_rd),
  .m_rd    (m_rd),
  .cfg_err (cfg_err),
  .m_start (m_start),
  .eos     (eos),
  .st      (st_q),
  .pos     (pos_q)
);

// File: tb/dual_seq_ctrl_test.sv
`timescale 1ns/1ps
module dual_seq_ctrl_test;

  localparam int ML = 16;
  localparam int CW = 5;
  localparam int DW = 16;
  localparam int NV = 7;

  // vector table: len-1, split, split-1, gate, xfer mode, master delay, slave delay
  localparam int V_LEN  [NV] = '{3, 15, 5, 4, 3, 4, 0};
  localparam int V_SPL  [NV] = '{0, 0, 1, 1, 0, 1, 0};
  localparam int V_SN   [NV] = '{0, 0, 1, 2, 0, 1, 0};
  localparam int V_GATE [NV] = '{0, 0, 0, 0, 1, 1, 1};
  localparam int V_XM   [NV] = '{1, 0, 3, 2, 1, 2, 3};
  localparam int V_MD   [NV] = '{3, 1, 2, 4, 2, 1, 2};
  localparam int V_SD   [NV] = '{2, 1, 4, 1, 3, 2, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, trig = 1'b0;
  logic [3:0] m_len_m1 = '0, s_len_m1 = '0;
  logic [ML*CW-1:0] m_list, s_list;
  logic split_en = 1'b0;
  logic [2:0] split_m1 = '0;
  logic rd_gate_en = 1'b0;
  logic [1:0] xfer_mode = '0;
  logic m_eoc = 1'b0, s_eoc = 1'b0;
  logic [DW-1:0] m_data = '0, s_data = '0;
  logic pw_rd = 1'b0, m_rd = 1'b0;
  logic m_start, s_start, eos, xfer_req, cfg_err;
  logic [CW-1:0] m_chan, s_chan;
  logic [2*DW-1:0] pair_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig),
    .m_len_m1(m_len_m1), .s_len_m1(s_len_m1),
    .m_list(m_list), .s_list(s_list),
    .split_en(split_en), .split_m1(split_m1),
    .rd_gate_en(rd_gate_en), .xfer_mode(xfer_mode),
    .m_eoc(m_eoc), .s_eoc(s_eoc), .m_data(m_data), .s_data(s_data),
    .pw_rd(pw_rd), .m_rd(m_rd),
    .m_start(m_start), .s_start(s_start), .m_chan(m_chan), .s_chan(s_chan),
    .pair_word(pair_word), .eos(eos), .xfer_req(xfer_req), .cfg_err(cfg_err)
  );

  function automatic logic [CW-1:0] mch(input int i);
    return CW'((i * 7 + 3) % 32);
  endfunction
  function automatic logic [CW-1:0] sch(input int i);
    return CW'((i * 11 + 20) % 32);
  endfunction
  function automatic logic [DW-1:0] mval(input int p);
    return DW'(16'hA000 + p);
  endfunction
  function automatic logic [DW-1:0] sval(input int p);
    return DW'(16'h5000 + p * 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask
  task automatic pulse_pw();
    @(negedge clk); pw_rd = 1'b1;
    @(negedge clk); pw_rd = 1'b0;
  endtask
  task automatic pulse_mrd();
    @(negedge clk); m_rd = 1'b1;
    @(negedge clk); m_rd = 1'b0;
  endtask

  // converter model for one pair; returns at the negedge after completion
  task automatic do_pair(input int md, input int sd, input int p);
    int mx;
    logic [31:0] prev;
    mx = (md > sd) ? md : sd;
    prev = pair_word;
    for (int k = 1; k <= mx; k++) begin
      @(negedge clk);
      if (k == mx && md != sd)
        chk(pair_word == prev, "R2 hold until both", pair_word, prev);
      m_eoc  = (k == md);
      s_eoc  = (k == sd);
      m_data = (k == md) ? mval(p) : 16'hDEAD;
      s_data = (k == sd) ? sval(p) : 16'hBEEF;
    end
    @(negedge clk);
    m_eoc = 1'b0;
    s_eoc = 1'b0;
    chk(pair_word == {sval(p), mval(p)}, "R2 paired word", pair_word,
        {sval(p), mval(p)});
  endtask

  task automatic setup(input int len, input bit spl, input int sn, input bit gate,
                       input int xm);
    @(negedge clk);
    en = 1'b0;
    m_len_m1 = 4'(len); s_len_m1 = 4'(len);
    split_en = spl; split_m1 = 3'(sn);
    rd_gate_en = gate; xfer_mode = 2'(xm);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic run_vec(input int v);
    int p, sub, len;
    bit last, slast, gate, xok;
    len  = V_LEN[v];
    gate = (V_GATE[v] != 0);
    xok  = (V_XM[v] != 0) && (!gate || V_XM[v] >= 2);
    setup(len, V_SPL[v] != 0, V_SN[v], gate, V_XM[v]);
    p = 0;
    while (p <= len) begin
      pulse_trig();
      chk(m_start && s_start, "R1 start pair", {m_start, s_start}, 2'b11);
      chk(m_chan == mch(p) && s_chan == sch(p), "R1 channels",
          {m_chan, s_chan}, {mch(p), sch(p)});
      sub = 0;
      forever begin
        do_pair(V_MD[v], V_SD[v], p);
        last  = (p == len);
        slast = (V_SPL[v] != 0) && (sub == V_SN[v]);
        chk(eos == last, "R3 eos", eos, last);
        chk(xfer_req == xok, "R10 xfer", xfer_req, xok);
        p++; sub++;
        if (gate) begin
          chk(!m_start, "R6 no start before read", m_start, 0);
          if (last || slast) begin
            pulse_trig();
            chk(!m_start, "R7 trig ignored in end hold", m_start, 0);
            pulse_pw();
            break;
          end
          @(negedge clk);
          chk(!m_start, "R6 still held", m_start, 0);
          if (p % 2 == 1) pulse_pw(); else pulse_mrd();
          chk(m_start, "R6 start after read", m_start, 1);
          chk(m_chan == mch(p), "R3 order", m_chan, mch(p));
        end else begin
          if (last || slast) begin
            chk(!m_start, "R5 stop at group end", m_start, 0);
            break;
          end
          chk(m_start, "R4 auto next", m_start, 1);
          chk(m_chan == mch(p) && s_chan == sch(p), "R3 order",
              {m_chan, s_chan}, {mch(p), sch(p)});
        end
      end
    end
    chk(m_chan == mch(0), "R3 wrap", m_chan, mch(0));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-run act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ML; i++) begin
      m_list[i*CW +: CW] = mch(i);
      s_list[i*CW +: CW] = sch(i);
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({m_start, s_start, eos, xfer_req} == 4'b0, "R12 pulses low",
        {m_start, s_start, eos, xfer_req}, 0);
    chk(pair_word == '0, "R12 word zero", pair_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_chan == mch(0), "R12 position 0", m_chan, mch(0));

    for (int v = 0; v < NV; v++) run_vec(v);

    // R9 mismatch
    @(negedge clk);
    en = 1'b0; m_len_m1 = 4'd3; s_len_m1 = 4'd2; rd_gate_en = 1'b0; split_en = 1'b0;
    @(negedge clk); en = 1'b1;
    chk(cfg_err, "R9 flag", cfg_err, 1);
    pulse_trig();
    chk(!m_start, "R9 no start", m_start, 0);
    @(negedge clk);
    chk(!m_start, "R9 still idle", m_start, 0);

    // R8 triggers while converting are dropped
    setup(1, 1'b0, 0, 1'b0, 0);
    pulse_trig();
    chk(m_start, "R8 first start", m_start, 1);
    pulse_trig();
    chk(!m_start, "R8 trig in conv dropped", m_start, 0);
    do_pair(1, 1, 0);
    chk(m_start && m_chan == mch(1), "R8 sequence unaffected", m_chan, mch(1));
    do_pair(2, 1, 1);
    chk(eos, "R8 end", eos, 1);
    @(negedge clk);
    chk(!m_start, "R8 not queued", m_start, 0);
    @(negedge clk);
    chk(!m_start, "R8 not queued later", m_start, 0);

    // R11 disable drops a pending hold
    setup(3, 1'b0, 0, 1'b1, 0);
    pulse_trig();
    do_pair(1, 2, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    chk(m_chan == mch(0), "R11 position reset", m_chan, mch(0));
    pulse_pw();
    chk(!m_start, "R11 hold discarded", m_start, 0);
    pulse_trig();
    chk(m_start && m_chan == mch(0), "R11 restart at 0", m_chan, mch(0));

    // R7 master read does not release the end hold
    setup(0, 1'b0, 0, 1'b1, 2);
    pulse_trig();
    do_pair(2, 1, 0);
    chk(eos && xfer_req, "R10 multi mode with gate", {eos, xfer_req}, 2'b11);
    pulse_mrd();
    pulse_trig();
    chk(!m_start, "R7 m_rd no release", m_start, 0);
    pulse_pw();
    pulse_trig();
    chk(m_start, "R7 released by pw_rd", m_start, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule